// File: doc/BRIEF.md
# Cable Fault Reflectometer Counter

This block is a read-only status word that measures the distance to a fault on a coax attachment-unit port. When a transmission starts, it begins counting periods of a 10 MHz timebase. A one-cycle enable at the system clock rate marks each of those periods. The first collision or loss-of-carrier indication after the start stops the count, and the count is then held.

Host software reads the word through a read strobe. Each read returns the count in the upper field and clears it. The lower field always carries a fixed identifier code, so software can tell which register it has read. The word can only be read; no path exists to write it.

The block runs on a single system clock with a synchronous, active-high reset. All inputs are sampled on that clock.

Top module: `tdr_counter_top`

## Requirements
- R1: After a synchronous reset the read word is 0x001C, the count is zero and no measurement is in progress.
- R2: Bits 15:6 of the read word carry the ten-bit count, and bits 5:0 always read binary 011100 (bit 0 is the LSB).
- R3: While measuring, each clock cycle with the tick enable high and no fault raises the count by exactly one.
- R4: A measurement begins on the cycle after a transmit-start pulse, from a count of zero. A tick in the same cycle as the start, or any tick while idle, is not counted.
- R5: The first collision or loss-of-carrier during a measurement freezes the count, and a tick in that same cycle is not counted. The frozen value then stays unchanged until it is read.
- R6: During a read cycle the word shows the current count, and the count is zero from the next cycle on. A read of a frozen value returns the block to idle.
- R7: The count saturates at 1023 and never wraps to zero while measuring.
- R8: A read in the same cycle as a counted tick returns the value from before the clear. Counting then restarts from zero and the measurement continues.
- R9: A transmit-start pulse while a value is frozen is ignored. It is not remembered after the read, so later ticks leave the count at zero.
- R10: Collision or loss-of-carrier while idle or while a value is frozen has no effect on the count.
- R11: A transmit-start pulse during a measurement restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | One-cycle pulse marking the start of a transmission |
| coll | input | 1 | Collision indication |
| loss_carrier | input | 1 | Loss-of-carrier error indication |
| tick | input | 1 | One-cycle enable per 10 MHz period |
| rd | input | 1 | Host read strobe; clears the count |
| rd_data | output | 16 | Read word: count in 15:6, identifier in 5:0 |

## Verification
The assertions assume that each input is a clean, synchronous level sampled once per system clock. They also assume that a fault may be held for several cycles without being counted twice, because only the transition into the frozen state matters. The bench drives every input on the falling clock edge and keeps tick as a single-cycle pulse, separated from the next one by at least one idle cycle. It samples the read word on the falling edge, so the pre-clear value shown in a read cycle and the cleared value after the edge can both be observed.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_HELD = 2'd2
    } tdr_state_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } tdr_cmd_t;

    localparam int TDR_CNT_W_DEF = 10;
    localparam int TDR_ID_W_DEF  = 6;
    localparam logic [TDR_ID_W_DEF-1:0] TDR_ID_DEF = 6'b011100;

endpackage

// File: rtl/tdr_ctrl.sv
module tdr_ctrl
    import tdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_start,
    input  logic       fault,
    input  logic       tick,
    input  logic       rd,
    output tdr_state_e state_q,
    output tdr_cmd_t   cmd
);

    tdr_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (tx_start) state_d = ST_MEAS;
            ST_MEAS: if (fault)    state_d = ST_HELD;
            ST_HELD: if (rd)       state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        cmd.clr = rd | (tx_start & (state_q != ST_HELD));
        cmd.inc = (state_q == ST_MEAS) & tick & ~fault;
    end

    // R5: a fault during a measurement always moves to the frozen state
    p_fault_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MEAS && fault) |=> state_q == ST_HELD);

    // R9: a start pulse while frozen leaves the state frozen
    p_held_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HELD && tx_start && !rd) |=> state_q == ST_HELD);

endmodule

// File: rtl/tdr_count.sv
module tdr_count
    import tdr_pkg::*;
#(
    parameter int CNT_W = TDR_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  tdr_cmd_t         cmd,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                               count_q <= '0;
        else if (cmd.clr)                      count_q <= '0;
        else if (cmd.inc && count_q != CNT_MAX) count_q <= count_q + 1'b1;
    end

    // R7: a full count does not wrap unless it is cleared
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_MAX && !cmd.clr) |=> count_q == CNT_MAX);

endmodule

// File: rtl/tdr_counter_top.sv
module tdr_counter_top
    import tdr_pkg::*;
#(
    parameter int                CNT_W   = TDR_CNT_W_DEF,
    parameter int                ID_W    = TDR_ID_W_DEF,
    parameter logic [ID_W-1:0]   ID_CODE = TDR_ID_DEF,
    localparam int               WORD_W  = CNT_W + ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic              coll,
    input  logic              loss_carrier,
    input  logic              tick,
    input  logic              rd,
    output logic [WORD_W-1:0] rd_data
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             fault;
    tdr_state_e       state_q;
    tdr_cmd_t         cmd;
    logic [CNT_W-1:0] count_q;

    assign fault = coll | loss_carrier;

    tdr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tx_start (tx_start),
        .fault    (fault),
        .tick     (tick),
        .rd       (rd),
        .state_q  (state_q),
        .cmd      (cmd)
    );

    tdr_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .count_q (count_q)
    );

    assign rd_data = {count_q, ID_CODE};

    // R3: a counted tick raises the count by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MEAS && tick && !fault && !rd && !tx_start && count_q != CNT_MAX)
        |=> count_q == $past(count_q) + 1'b1);

    // R4: no count accumulates while idle
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> count_q == '0);

    // R5: a frozen value stays put until read
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HELD && !rd) |=> $stable(count_q));

    // R6: a read leaves the count at zero
    p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
        rd |=> count_q == '0);

    // R10: faults outside a measurement leave the count unchanged
    p_fault_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_MEAS && fault && !rd && !tx_start) |=> $stable(count_q));

    // R11: a start outside the frozen state restarts from zero
    p_restart_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_HELD && tx_start) |=> count_q == '0);

endmodule

// File: tb/tdr_counter_top_tb.sv
`timescale 1ns/1ps
module tdr_counter_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_start = 1'b0;
    logic        coll = 1'b0;
    logic        loss_carrier = 1'b0;
    logic        tick = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    tdr_counter_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .tx_start     (tx_start),
        .coll         (coll),
        .loss_carrier (loss_carrier),
        .tick         (tick),
        .rd           (rd),
        .rd_data      (rd_data)
    );

    typedef struct packed {
        logic        start;
        logic [10:0] ticks;
        logic [15:0] exp;
    } row_t;

    localparam int NROWS = 6;
    localparam row_t ROWS [NROWS] = '{
        '{1'b1, 11'd5,    16'h015C},  // R3 R5
        '{1'b1, 11'd0,    16'h001C},  // R5 fault before any tick
        '{1'b1, 11'd37,   16'h095C},  // R3 R2
        '{1'b1, 11'd1023, 16'hFFDC},  // R7 exactly full
        '{1'b1, 11'd1030, 16'hFFDC},  // R7 saturation
        '{1'b0, 11'd10,   16'h001C}   // R4 R10 idle ticks and fault
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        tx_start = 1'b1; cycle(); tx_start = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1; cycle(); tick = 1'b0; cycle();
        end
    endtask

    task automatic fault_pulse(input bit use_coll);
        if (use_coll) coll = 1'b1; else loss_carrier = 1'b1;
        cycle();
        coll = 1'b0; loss_carrier = 1'b0;
    endtask

    task automatic do_read(input string tag, input logic [15:0] exp);
        rd = 1'b1;
        #1 chk(tag, rd_data, exp);
        cycle();
        rd = 1'b0;
        #1 chk("R6 cleared after read", rd_data, 16'h001C);
    endtask

    initial begin
        cycle(); cycle();
        chk("R1 reset word", rd_data, 16'h001C);
        chk("R2 id bits", {10'd0, rd_data[5:0]}, 16'h001C);
        rst = 1'b0;
        cycle();

        for (int i = 0; i < NROWS; i++) begin
            if (ROWS[i].start) pulse_start();
            ticks(int'(ROWS[i].ticks));
            fault_pulse(i[0]);
            ticks(3);
            do_read($sformatf("R3/R5/R7 row %0d", i), ROWS[i].exp);
        end

        // R4: tick in the start cycle is not counted
        tx_start = 1'b1; tick = 1'b1; cycle(); tx_start = 1'b0; tick = 1'b0; cycle();
        ticks(2);
        fault_pulse(1'b1);
        do_read("R4 start-cycle tick", 16'h009C);

        // R5: tick with the fault in the same cycle is not counted
        pulse_start(); ticks(3);
        tick = 1'b1; coll = 1'b1; cycle(); tick = 1'b0; coll = 1'b0;
        #1 chk("R5 fault wins over tick", rd_data, 16'h00DC);

        // R9/R10: start and fault while frozen are ignored
        pulse_start(); fault_pulse(1'b0); ticks(5);
        #1 chk("R9 start ignored while held", rd_data, 16'h00DC);
        do_read("R10 held value intact", 16'h00DC);
        ticks(4);
        #1 chk("R9 start not remembered", rd_data, 16'h001C);

        // R8: read together with a tick during a measurement
        pulse_start(); ticks(4);
        rd = 1'b1; tick = 1'b1;
        #1 chk("R8 pre-clear value", rd_data, 16'h011C);
        cycle(); rd = 1'b0; tick = 1'b0; cycle();
        ticks(2);
        #1 chk("R8 restarted from zero", rd_data, 16'h009C);
        fault_pulse(1'b1);
        do_read("R8 after restart", 16'h009C);

        // R11: start during a measurement restarts it
        pulse_start(); ticks(6); pulse_start(); ticks(2);
        fault_pulse(1'b0);
        do_read("R11 restart", 16'h009C);

        // R1: reset in the middle of a measurement
        pulse_start(); ticks(7);
        rst = 1'b1; cycle(); rst = 1'b0;
        #1 chk("R1 reset mid-measure", rd_data, 16'h001C);
        ticks(3);
        #1 chk("R1 idle after reset", rd_data, 16'h001C);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule